// File: doc/BRIEF.md
# Self-Calibration Trigger Sequencer

This block decides when a converter's self-calibration cycle runs. After reset it waits a fixed number of clock cycles and then launches an automatic calibration. A delay-select input chooses a long or a short wait and works the same way in either control mode. After that first opportunity, calibrations run only on command. A command is a qualified low-then-high cycle on a trigger. In extended control mode the trigger is the trigger pin ORed with a calibration bit from the control register. In the basic mode the trigger is the pin alone. The trigger pin passes through a two-flop synchroniser before it is qualified. The register bit is already synchronous and enters the OR directly.

The sequencer sends a one-cycle start pulse to the calibration engine. It then holds a busy flag until the engine returns a done pulse. While the trigger is high at power-on, the automatic calibration is withheld until the trigger has gone low and then high again. Trigger activity while a calibration is starting or running has no effect. The trigger must show a new low period after busy drops before another calibration can start.

The main state machine has four states. SEQ_POR_WAIT counts the power-on delay. When the count ends it moves to SEQ_START, or to SEQ_IDLE if the combined trigger is high at that moment. SEQ_IDLE moves to SEQ_START on a qualified trigger. SEQ_START always moves to SEQ_RUN after one cycle. SEQ_RUN moves to SEQ_IDLE on done. The qualifier has two states. QL_LOW_WAIT counts consecutive low cycles and moves to QL_ARMED once enough have been seen. QL_ARMED counts consecutive high cycles. A low cycle clears the high count but keeps the qualifier armed. Reaching the high minimum fires a request and returns the qualifier to QL_LOW_WAIT. The qualifier is held in QL_LOW_WAIT with cleared counts whenever the main machine is not in SEQ_IDLE.

Top module: `cal_seq_top`

## Requirements
- R1: While reset is asserted, cal_start_o and cal_busy_o are both low.
- R2: With the trigger low, cal_start_o goes high exactly SHORT_DLY rising clock edges after reset release when dly_long_i is low, or LONG_DLY edges when it is high. This holds in either control mode, with dly_long_i held steady during the wait.
- R3: If the combined trigger is high when the power-on wait ends, no automatic calibration starts. A later qualified low-then-high trigger cycle starts one.
- R4: The combined trigger arms only after it has been low for MIN_LOW consecutive cycles. A low period of MIN_LOW-1 cycles arms nothing.
- R5: Once armed, a start needs MIN_HIGH consecutive high cycles. A high period that ends early restarts the high count but keeps the arming, so a short low gap followed by a full high period still starts a calibration.
- R6: A rising edge on trig_pin_i of an armed, idle sequencer gives cal_start_o high after exactly MIN_HIGH+2 rising edges, which includes the two synchroniser stages.
- R7: With ext_mode_i high, the combined trigger is trig_pin_i OR cal_reg_bit_i. Both must be low to arm. A rising cal_reg_bit_i on an armed sequencer gives cal_start_o after exactly MIN_HIGH rising edges.
- R8: With ext_mode_i low, cal_reg_bit_i has no effect on arming or starting.
- R9: cal_start_o is a single-cycle pulse, and cal_busy_o rises on the cycle right after it.
- R10: cal_busy_o stays high until cal_done_i is seen and falls on the next cycle. cal_done_i has no effect when busy is low.
- R11: Trigger activity while busy is high starts nothing. After busy falls, a new low period of MIN_LOW cycles is needed before a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-on) |
| dly_long_i | input | 1 | Power-on delay select: 1 long, 0 short |
| trig_pin_i | input | 1 | Asynchronous calibration trigger pin |
| ext_mode_i | input | 1 | Extended control mode enable |
| cal_reg_bit_i | input | 1 | Calibration bit from the control register, synchronous |
| cal_done_i | input | 1 | Single-cycle completion pulse from the calibration engine |
| cal_start_o | output | 1 | Single-cycle calibration start pulse |
| cal_busy_o | output | 1 | High while a calibration runs |

## Verification
The start pulse is due SHORT_DLY or LONG_DLY edges after reset release. It is due MIN_HIGH+2 edges after a pin rise, because the pin passes through two synchroniser flops, and MIN_HIGH edges after a register-bit rise. Busy follows one edge after the start pulse, and busy falls one edge after done. Every input changes on a falling clock edge, and the bench counts rising edges from that change. It checks the output at the falling edge one cycle before the expected change and again at the falling edge where the change is due. Cases that must start nothing watch cal_start_o at every falling edge over the whole window.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;
    typedef enum logic [1:0] {
        SEQ_POR_WAIT,
        SEQ_IDLE,
        SEQ_START,
        SEQ_RUN
    } seq_state_t;

    typedef enum logic {
        QL_LOW_WAIT,
        QL_ARMED
    } qual_state_t;
endpackage

// File: rtl/cal_sync2.sv
module cal_sync2 #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= {shreg[STAGES-2:0], d_i};
    end

    assign q_o = shreg[STAGES-1];
endmodule

// File: rtl/cal_trig_qual.sv
module cal_trig_qual
    import cal_seq_pkg::*;
#(
    parameter int MIN_LOW  = 8,
    parameter int MIN_HIGH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_i,
    input  logic trig_i,
    output logic fire_o
);
    localparam int LW = $clog2(MIN_LOW + 1);
    localparam int HW = $clog2(MIN_HIGH + 1);
    localparam logic [LW-1:0] LOW_LAST  = LW'(MIN_LOW - 1);
    localparam logic [HW-1:0] HIGH_LAST = HW'(MIN_HIGH - 1);

    qual_state_t    st, st_nx;
    logic [LW-1:0]  lcnt, lcnt_nx;
    logic [HW-1:0]  hcnt, hcnt_nx;
    logic           fire;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= QL_LOW_WAIT;
            lcnt <= '0;
            hcnt <= '0;
        end else begin
            st   <= st_nx;
            lcnt <= lcnt_nx;
            hcnt <= hcnt_nx;
        end
    end

    always_comb begin
        st_nx   = st;
        lcnt_nx = lcnt;
        hcnt_nx = hcnt;
        fire    = 1'b0;
        if (hold_i) begin
            st_nx   = QL_LOW_WAIT;
            lcnt_nx = '0;
            hcnt_nx = '0;
        end else begin
            unique case (st)
                QL_LOW_WAIT: begin
                    hcnt_nx = '0;
                    if (trig_i) begin
                        lcnt_nx = '0;
                    end else if (lcnt == LOW_LAST) begin
                        lcnt_nx = '0;
                        st_nx   = QL_ARMED;
                    end else begin
                        lcnt_nx = lcnt + 1'b1;
                    end
                end
                QL_ARMED: begin
                    if (!trig_i) begin
                        hcnt_nx = '0;
                    end else if (hcnt == HIGH_LAST) begin
                        fire    = 1'b1;
                        hcnt_nx = '0;
                        st_nx   = QL_LOW_WAIT;
                    end else begin
                        hcnt_nx = hcnt + 1'b1;
                    end
                end
            endcase
        end
    end

    assign fire_o = fire;
endmodule

// File: rtl/cal_seq_top.sv
module cal_seq_top
    import cal_seq_pkg::*;
#(
    parameter int LONG_DLY    = 1024,
    parameter int SHORT_DLY   = 64,
    parameter int MIN_LOW     = 8,
    parameter int MIN_HIGH    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dly_long_i,
    input  logic trig_pin_i,
    input  logic ext_mode_i,
    input  logic cal_reg_bit_i,
    input  logic cal_done_i,
    output logic cal_start_o,
    output logic cal_busy_o
);
    localparam int DW = $clog2(LONG_DLY + 1);
    localparam logic [DW-1:0] LONG_LAST  = DW'(LONG_DLY - 1);
    localparam logic [DW-1:0] SHORT_LAST = DW'(SHORT_DLY - 1);

    seq_state_t    state, state_nx;
    logic [DW-1:0] dcnt, dcnt_nx;
    logic [DW-1:0] dly_last;
    logic          pin_s;
    logic          trig_c;
    logic          fire;

    cal_sync2 #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (trig_pin_i),
        .q_o   (pin_s)
    );

    assign trig_c = pin_s | (ext_mode_i & cal_reg_bit_i);

    cal_trig_qual #(.MIN_LOW(MIN_LOW), .MIN_HIGH(MIN_HIGH)) u_qual (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold_i (state != SEQ_IDLE),
        .trig_i (trig_c),
        .fire_o (fire)
    );

    assign dly_last = dly_long_i ? LONG_LAST : SHORT_LAST;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SEQ_POR_WAIT;
            dcnt  <= '0;
        end else begin
            state <= state_nx;
            dcnt  <= dcnt_nx;
        end
    end

    always_comb begin
        state_nx = state;
        dcnt_nx  = dcnt;
        unique case (state)
            SEQ_POR_WAIT: begin
                if (dcnt >= dly_last) begin
                    dcnt_nx  = '0;
                    state_nx = trig_c ? SEQ_IDLE : SEQ_START;
                end else begin
                    dcnt_nx = dcnt + 1'b1;
                end
            end
            SEQ_IDLE:  if (fire) state_nx = SEQ_START;
            SEQ_START: state_nx = SEQ_RUN;
            SEQ_RUN:   if (cal_done_i) state_nx = SEQ_IDLE;
        endcase
    end

    always_comb begin
        cal_start_o = (state == SEQ_START);
        cal_busy_o  = (state == SEQ_RUN);
    end
endmodule

// File: rtl/cal_seq_chk.sv
module cal_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done
);
    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);  // R9
    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);  // R9
    AST_BUSY_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));  // R9
    AST_BUSY_ENDS_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && done) |=> !busy);  // R10
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);  // R10
    AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start);  // R11
endmodule

bind cal_seq_top cal_seq_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (cal_start_o),
    .busy  (cal_busy_o),
    .done  (cal_done_i)
);

// File: tb/cal_seq_top_tb.sv
module cal_seq_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LONG_DLY   = 40;
    localparam int SHORT_DLY  = 12;
    localparam int MIN_LOW    = 4;
    localparam int MIN_HIGH   = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dly_long_i = 1'b0;
    logic trig_pin_i = 1'b0;
    logic ext_mode_i = 1'b0;
    logic cal_reg_bit_i = 1'b0;
    logic cal_done_i = 1'b0;
    logic cal_start_o;
    logic cal_busy_o;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cal_seq_top #(
        .LONG_DLY(LONG_DLY), .SHORT_DLY(SHORT_DLY),
        .MIN_LOW(MIN_LOW), .MIN_HIGH(MIN_HIGH)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .dly_long_i(dly_long_i),
        .trig_pin_i(trig_pin_i), .ext_mode_i(ext_mode_i),
        .cal_reg_bit_i(cal_reg_bit_i), .cal_done_i(cal_done_i),
        .cal_start_o(cal_start_o), .cal_busy_o(cal_busy_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic advance(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic watch_no_start(input int n, input string req);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (cal_start_o) seen++;
        end
        check(req, seen, 0);
    endtask

    task automatic do_reset(input logic dly, input logic pin, input logic ext);
        @(negedge clk);
        rst_n = 1'b0;
        dly_long_i = dly;
        trig_pin_i = pin;
        ext_mode_i = ext;
        cal_reg_bit_i = 1'b0;
        cal_done_i = 1'b0;
        advance(3);
        check("R1 start in reset", int'(cal_start_o), 0);
        check("R1 busy in reset", int'(cal_busy_o), 0);
        rst_n = 1'b1;
    endtask

    task automatic finish_cal(input string req);
        advance(1);
        check(req, int'(cal_busy_o), 1);
        cal_done_i = 1'b1;
        advance(1);
        check("R10 busy falls after done", int'(cal_busy_o), 0);
        cal_done_i = 1'b0;
    endtask

    task automatic pin_start(input string req);
        trig_pin_i = 1'b1;
        advance(MIN_HIGH + 1);
        check(req, int'(cal_start_o), 0);
        advance(1);
        check(req, int'(cal_start_o), 1);
    endtask

    task automatic t_por_short;
        do_reset(1'b0, 1'b0, 1'b0);
        advance(SHORT_DLY - 1);
        check("R2 short wait early", int'(cal_start_o), 0);
        advance(1);
        check("R2 short wait start", int'(cal_start_o), 1);
        check("R9 busy low during start", int'(cal_busy_o), 0);
        advance(1);
        check("R9 start single cycle", int'(cal_start_o), 0);
        check("R9 busy after start", int'(cal_busy_o), 1);
        cal_done_i = 1'b1;
        advance(1);
        check("R10 busy falls after done", int'(cal_busy_o), 0);
        cal_done_i = 1'b0;
        cal_done_i = 1'b1;
        advance(1);
        cal_done_i = 1'b0;
        check("R10 done while idle start", int'(cal_start_o), 0);
        check("R10 done while idle busy", int'(cal_busy_o), 0);
    endtask

    task automatic t_por_long;
        do_reset(1'b1, 1'b0, 1'b1);
        advance(LONG_DLY - 1);
        check("R2 long wait early", int'(cal_start_o), 0);
        advance(1);
        check("R2 long wait start", int'(cal_start_o), 1);
        advance(1);
        advance(5);
        check("R10 busy holds without done", int'(cal_busy_o), 1);
        cal_done_i = 1'b1;
        advance(1);
        check("R10 busy falls after done", int'(cal_busy_o), 0);
        cal_done_i = 1'b0;
        ext_mode_i = 1'b0;
    endtask

    task automatic t_inhibit;
        do_reset(1'b0, 1'b1, 1'b0);
        watch_no_start(SHORT_DLY + 10, "R3 no auto cal with trigger high");
        check("R3 busy stays low", int'(cal_busy_o), 0);
        trig_pin_i = 1'b0;
        advance(MIN_LOW + 4);
        pin_start("R3 R6 start after low-high cycle");
        finish_cal("R9 busy after start");
    endtask

    task automatic t_low_time;
        trig_pin_i = 1'b0;
        advance(MIN_LOW - 1);
        trig_pin_i = 1'b1;
        watch_no_start(MIN_HIGH + 6, "R4 short low does not arm");
        trig_pin_i = 1'b0;
        advance(MIN_LOW);
        pin_start("R4 R6 exact low time arms");
        finish_cal("R9 busy after start");
    endtask

    task automatic t_high_time;
        trig_pin_i = 1'b0;
        advance(MIN_LOW + 3);
        trig_pin_i = 1'b1;
        watch_no_start(MIN_HIGH - 1, "R5 short high no start");
        trig_pin_i = 1'b0;
        watch_no_start(2, "R5 gap no start");
        pin_start("R5 arming kept after short high");
        finish_cal("R9 busy after start");
    endtask

    task automatic t_busy_ignore;
        trig_pin_i = 1'b0;
        advance(MIN_LOW + 3);
        pin_start("R6 pin start latency");
        advance(1);
        check("R9 busy after start", int'(cal_busy_o), 1);
        trig_pin_i = 1'b0;
        advance(MIN_LOW + 3);
        trig_pin_i = 1'b1;
        watch_no_start(MIN_HIGH + 5, "R11 trigger ignored while busy");
        check("R11 busy unaffected", int'(cal_busy_o), 1);
        cal_done_i = 1'b1;
        advance(1);
        cal_done_i = 1'b0;
        check("R10 busy falls after done", int'(cal_busy_o), 0);
        watch_no_start(MIN_HIGH + 8, "R11 no start without fresh low");
        trig_pin_i = 1'b0;
        advance(MIN_LOW + 3);
        pin_start("R11 start after fresh low");
        finish_cal("R9 busy after start");
    endtask

    task automatic t_ext_mode;
        ext_mode_i = 1'b1;
        trig_pin_i = 1'b0;
        cal_reg_bit_i = 1'b1;
        advance(MIN_LOW + 5);
        trig_pin_i = 1'b1;
        watch_no_start(MIN_HIGH + 6, "R7 bit high blocks arming");
        trig_pin_i = 1'b0;
        cal_reg_bit_i = 1'b0;
        advance(MIN_LOW + 3);
        cal_reg_bit_i = 1'b1;
        advance(MIN_HIGH - 1);
        check("R7 bit start early", int'(cal_start_o), 0);
        advance(1);
        check("R7 bit start", int'(cal_start_o), 1);
        finish_cal("R9 busy after start");
        cal_reg_bit_i = 1'b0;
    endtask

    task automatic t_basic_mode;
        ext_mode_i = 1'b0;
        trig_pin_i = 1'b0;
        cal_reg_bit_i = 1'b0;
        advance(MIN_LOW + 3);
        cal_reg_bit_i = 1'b1;
        watch_no_start(MIN_HIGH + 6, "R8 bit ignored in basic mode");
        pin_start("R8 pin still arms with bit high");
        finish_cal("R9 busy after start");
        cal_reg_bit_i = 1'b0;
    endtask

    task automatic report;
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        t_por_short();
        t_por_long();
        t_inhibit();
        t_low_time();
        t_high_time();
        t_busy_ignore();
        t_ext_mode();
        t_basic_mode();
        report();
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end
endmodule